// File: doc/BRIEF.md
# Four-Channel Edge-Selectable Timestamp Capture

This block timestamps external events against one shared 16-bit up-counter. Each of four channels samples its own asynchronous input pin through a two-stage synchronizer. It then looks for a transition of the kind software selected: rising, falling, either, or none. When that transition is found, the channel copies the current counter value into its own capture register and sets a sticky event flag. Software clears the flag by writing a one to it.

An 8-bit control register holds a 2-bit edge-select code for each channel. The fourth channel (D) has a second trigger source. While its pin capture is switched off, it stores the counter value on every pulse of a compare-match strobe that comes from another timer. The other channels never react to that strobe.

Software reaches the block through a small synchronous write port and a combinational read port. The reset input is expected to be deasserted synchronously to `clk` by the reset network upstream of the block.

Top module: `edgecap_quad`

## Requirements
- R1: After reset the control register, all four event flags and all four capture registers read 0, and the counter restarts from 0.
- R2: The counter adds one on every clock edge outside reset and wraps from 0xFFFF to 0x0000.
- R3: Address 0 reads and writes the 8-bit control register. Channel A's code sits in bits 1:0, B in 3:2, C in 5:4 and D in 7:6. Read bits 15:8 are 0.
- R4: Code 01 makes a channel capture on a low-to-high transition of its pin only.
- R5: Code 10 makes a channel capture on a high-to-low transition of its pin only.
- R6: Code 11 makes a channel capture on transitions in both directions.
- R7: Code 00 on channels A, B or C makes pin transitions leave the capture register and the flag of that channel unchanged.
- R8: With channel D at code 00, each cycle in which `cmp_strobe` is high stores the counter into capture D and sets flag D, and pin D transitions are ignored. With channel D nonzero, and on channels A to C in every mode, `cmp_strobe` changes no capture register and no flag.
- R9: A pin change driven just after a clock edge is detected after two synchronizer stages. The capture register then holds the counter value present in that detection cycle, and the flag is visible one clock after detection, which is three rising edges after the pin change.
- R10: Flags are sticky and appear on `cap_flag` (bit n = channel n, A = 0). Writing address 1 clears each flag whose `reg_wdata` bit is 1 and leaves the others alone. A capture in the same cycle as a clear leaves the flag set.
- R11: A control write takes effect on the clock edge that ends the write cycle. A transition detected in that same cycle is judged by the previous code.
- R12: Addresses 2, 3, 4 and 5 read capture A, B, C and D. Address 1 reads the flags in bits 3:0. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cap_pin | input | 4 | Asynchronous event pins, bit n feeds channel n |
| cmp_strobe | input | 1 | Compare-match pulse from another counter, synchronous to clk |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| cap_flag | output | 4 | Sticky capture event flags |

## Verification
A control-register write and a pin transition that has just cleared the synchronizer can land in the same clock cycle. In that case the transition must be judged by the code that was in force before the write. The bench lines the two up by driving the pin two edges before it issues the write. It checks both directions: switching a rising-edge channel off still captures, and switching an idle channel on does not. It also puts a strobe capture on channel D in the same cycle as a write that clears flag D, and expects the flag to stay set with the new timestamp.

// File: rtl/edgecap_pkg.sv
package edgecap_pkg;

  typedef enum logic [1:0] {
    ES_OFF  = 2'b00,
    ES_RISE = 2'b01,
    ES_FALL = 2'b10,
    ES_BOTH = 2'b11
  } edge_sel_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_FLAG = 1;
  localparam int ADDR_CAP0 = 2;

endpackage

// File: rtl/edgecap_sync.sv
module edgecap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= level;
    end
  end

  assign rise_o = level & ~prev_q;
  assign fall_o = ~level & prev_q;

endmodule

// File: rtl/edgecap_chan.sv
module edgecap_chan
  import edgecap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit ALT_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  edge_sel_e        sel_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             alt_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);

  logic hit;
  logic flag_d;

  always_comb begin
    unique case (sel_i)
      ES_OFF:  hit = ALT_EN & alt_i;
      ES_RISE: hit = rise_i;
      ES_FALL: hit = fall_i;
      default: hit = rise_i | fall_i;
    endcase
    // a capture in the clear cycle wins
    flag_d = hit | (flag_o & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (hit) cap_o <= cnt_i;
      flag_o <= flag_d;
    end
  end

  p_rise_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == ES_RISE && rise_i) |=> (cap_o == $past(cnt_i) && flag_o));

  p_fall_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == ES_FALL && fall_i) |=> (cap_o == $past(cnt_i) && flag_o));

  p_both_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == ES_BOTH && (rise_i || fall_i)) |=> (cap_o == $past(cnt_i)));

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == ES_OFF && !(ALT_EN && alt_i)) |=> $stable(cap_o));

  p_alt_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ALT_EN && sel_i == ES_OFF && alt_i) |=> (cap_o == $past(cnt_i) && flag_o));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/edgecap_quad.sv
module edgecap_quad
  import edgecap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_CH      = 4,
  parameter int ALT_CH      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     cap_pin,
  input  logic                  cmp_strobe,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [2*NUM_CH-1:0]   reg_wdata,
  output logic [CNT_W-1:0]      reg_rdata,
  output logic [NUM_CH-1:0]     cap_flag
);

  localparam int CTRL_W = 2 * NUM_CH;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr;
  logic              flag_wr;
  logic [NUM_CH-1:0] clr_v;
  logic [NUM_CH-1:0] rise_v;
  logic [NUM_CH-1:0] fall_v;
  logic [NUM_CH-1:0] flag_v;
  logic [CNT_W-1:0]  cap_arr [NUM_CH];

  // free-running timebase
  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // register port decode
  always_comb begin
    ctrl_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
    flag_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_FLAG));
    clr_v   = flag_wr ? reg_wdata[NUM_CH-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= reg_wdata;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    edgecap_sync #(
      .STAGES (SYNC_STAGES)
    ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (cap_pin[i]),
      .rise_o (rise_v[i]),
      .fall_o (fall_v[i])
    );

    edgecap_chan #(
      .CNT_W  (CNT_W),
      .ALT_EN (i == ALT_CH)
    ) chan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (edge_sel_e'(ctrl_q[2*i +: 2])),
      .rise_i (rise_v[i]),
      .fall_i (fall_v[i]),
      .alt_i  (cmp_strobe),
      .clr_i  (clr_v[i]),
      .cnt_i  (cnt_q),
      .cap_o  (cap_arr[i]),
      .flag_o (flag_v[i])
    );
  end

  assign cap_flag = flag_v;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
      reg_rdata = CNT_W'(ctrl_q);
    end else if (reg_addr == ADDR_W'(ADDR_FLAG)) begin
      reg_rdata = CNT_W'(flag_v);
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (reg_addr == ADDR_W'(ADDR_CAP0 + i)) reg_rdata = cap_arr[i];
      end
    end
  end

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q == $past(reg_wdata)));

  p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q));

  p_strobe_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_strobe && ctrl_q[2*ALT_CH +: 2] != 2'b00
     && !rise_v[ALT_CH] && !fall_v[ALT_CH]) |=> $stable(cap_arr[ALT_CH]));

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && reg_wdata[0] && ctrl_q[1:0] == 2'b00) |=> !flag_v[0]);

endmodule

// File: tb/edgecap_quad_tb.sv
module edgecap_quad_tb_top;

  logic        clk;
  logic        rst_n;
  logic [3:0]  pins;
  logic        cmp;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [15:0] reg_rdata;
  logic [3:0]  cap_flag;

  logic [15:0] mdl;
  logic [7:0]  sh_ctrl;
  int          n_tests;
  int          n_fail;
  bit          done;

  edgecap_quad dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_pin    (pins),
    .cmp_strobe (cmp),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cap_flag   (cap_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected timebase from R1/R2
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdl <= 16'h0000;
    else        mdl <= mdl + 16'h0001;
  end

  function automatic bit exp_hit(input logic [1:0] m, input logic p, input logic l);
    case (m)
      2'b01:   return (!p && l);
      2'b10:   return (p && !l);
      2'b11:   return (p != l);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 v = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_mode(input int ch, input logic [1:0] m);
    sh_ctrl[2*ch +: 2] = m;
    wr(0, sh_ctrl);
  endtask

  task automatic pin_step(input int ch, input logic lvl);
    logic [15:0] old_c, got, ec;
    logic        prv;
    logic [1:0]  m;
    bit          h;
    string       rq;
    rd(2 + ch, old_c);
    wr(1, 8'h0F);
    prv = pins[ch];
    m   = sh_ctrl[2*ch +: 2];
    @(negedge clk) pins[ch] = lvl;
    @(posedge clk); @(posedge clk);
    @(negedge clk) ec = mdl;
    @(negedge clk);
    reg_addr = 3'(2 + ch);
    #1 got = reg_rdata;
    h = exp_hit(m, prv, lvl);
    case (m)
      2'b01:   rq = "R4";
      2'b10:   rq = "R5";
      2'b11:   rq = "R6";
      default: rq = (ch == 3) ? "R8" : "R7";
    endcase
    chk(rq, "flags after pin change", {28'h0, cap_flag}, h ? (32'h1 << ch) : 32'h0);
    chk(h ? "R9" : rq, "capture after pin change", {16'h0, got}, h ? {16'h0, ec} : {16'h0, old_c});
  endtask

  task automatic strobe_chk();
    logic [15:0] old_c [4];
    logic [15:0] got, ec;
    bit          h;
    for (int c = 0; c < 4; c++) rd(2 + c, old_c[c]);
    wr(1, 8'h0F);
    h = (sh_ctrl[7:6] == 2'b00);
    @(negedge clk) cmp = 1'b1; ec = mdl;
    @(negedge clk) cmp = 1'b0;
    #1 chk("R8", "flags after strobe", {28'h0, cap_flag}, h ? 32'h8 : 32'h0);
    rd(5, got);
    chk("R8", "capture D after strobe", {16'h0, got}, h ? {16'h0, ec} : {16'h0, old_c[3]});
    for (int c = 0; c < 3; c++) begin
      rd(2 + c, got);
      chk("R8", "capture A-C unchanged by strobe", {16'h0, got}, {16'h0, old_c[c]});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, old_c, ec;
    int          seed;
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; pins = 4'h0; cmp = 1'b0;
    reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00; sh_ctrl = 8'h00;
    seed = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk("R1", "register in reset", {16'h0, v}, 32'h0);
    end
    @(negedge clk) rst_n = 1'b1;
    chk("R1", "flags out of reset", {28'h0, cap_flag}, 32'h0);

    // R1 / R2 counter restart, via strobe on D at code 00
    strobe_chk();

    // R3 control layout readback
    wr(0, 8'hE4);
    rd(0, v);
    chk("R3", "control readback", {16'h0, v}, 32'h00E4);
    wr(0, 8'h00);

    // R12 unused addresses
    rd(6, v); chk("R12", "address 6", {16'h0, v}, 32'h0);
    rd(7, v); chk("R12", "address 7", {16'h0, v}, 32'h0);

    // directed modes on channel B (bits 3:2, R3 placement)
    set_mode(1, 2'b01); pin_step(1, 1'b1); pin_step(1, 1'b0);
    set_mode(1, 2'b10); pin_step(1, 1'b1); pin_step(1, 1'b0);
    set_mode(1, 2'b11); pin_step(1, 1'b1); pin_step(1, 1'b0);
    set_mode(1, 2'b00); pin_step(1, 1'b1); pin_step(1, 1'b0);
    // channel D pin ignored at 00, used at 01
    set_mode(3, 2'b00); pin_step(3, 1'b1); pin_step(3, 1'b0);
    set_mode(3, 2'b01); pin_step(3, 1'b1);
    // strobe ignored while D nonzero
    strobe_chk();
    set_mode(3, 2'b00); pin_step(3, 1'b0);
    strobe_chk();

    // R11 edge in the write cycle judged by the old code (A rising -> off)
    set_mode(0, 2'b01);
    wr(1, 8'h0F);
    @(negedge clk) pins[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    sh_ctrl[1:0] = 2'b00;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = sh_ctrl; ec = mdl;
    @(negedge clk) reg_wr = 1'b0;
    #1 chk("R11", "flag A with old rising code", {28'h0, cap_flag}, 32'h1);
    rd(2, v);
    chk("R11", "capture A with old rising code", {16'h0, v}, {16'h0, ec});
    // off -> falling in the edge cycle: no capture
    wr(1, 8'h0F);
    rd(2, old_c);
    @(negedge clk) pins[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    sh_ctrl[1:0] = 2'b10;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = sh_ctrl;
    @(negedge clk) reg_wr = 1'b0;
    #1 chk("R11", "flag A with old off code", {28'h0, cap_flag}, 32'h0);
    rd(2, v);
    chk("R11", "capture A with old off code", {16'h0, v}, {16'h0, old_c});
    pin_step(0, 1'b1);
    pin_step(0, 1'b0);

    // R10 clear and capture in the same cycle; selective clear
    set_mode(3, 2'b00);
    strobe_chk();
    @(negedge clk);
    cmp = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h08; ec = mdl;
    @(negedge clk) cmp = 1'b0; reg_wr = 1'b0;
    #1 chk("R10", "flag D set beats clear", {28'h0, cap_flag}, 32'h8);
    rd(5, v);
    chk("R10", "capture D in clear cycle", {16'h0, v}, {16'h0, ec});
    rd(1, v);
    chk("R12", "flag readback", {16'h0, v}, 32'h8);
    wr(1, 8'h07);
    chk("R10", "other bits do not clear D", {28'h0, cap_flag}, 32'h8);
    wr(1, 8'h08);
    chk("R10", "write one clears D", {28'h0, cap_flag}, 32'h0);

    // random modes and pin patterns
    for (int k = 0; k < 60; k++) begin
      int          ch;
      logic [1:0]  m;
      logic        l;
      ch = $urandom_range(0, 3);
      m  = 2'($urandom_range(0, 3));
      l  = ($urandom_range(0, 3) == 0) ? pins[ch] : ~pins[ch];
      set_mode(ch, m);
      pin_step(ch, l);
    end

    // R2 wrap through strobe captures on D
    set_mode(3, 2'b00);
    wr(1, 8'h0F);
    reg_addr = 3'd5;
    while (mdl != 16'hFFFF) @(negedge clk);
    cmp = 1'b1;
    @(negedge clk);
    #1 chk("R2", "capture at top of count", {16'h0, reg_rdata}, 32'hFFFF);
    @(negedge clk) cmp = 1'b0;
    #1 chk("R2", "capture after wrap", {16'h0, reg_rdata}, 32'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule